// File: doc/BRIEF.md
# Two-Stage Serial Baud Tick Generator

This block produces the timing enables for an asynchronous serial port from the system clock. A prescaler divides by one of four fixed ratios: 1, 3, 4 or 13. A binary rate stage follows it and divides by a power of two from 1 to 128. The output of the two stages is the receive-sample enable, which runs at sixteen times the bit rate. A fixed divide-by-sixteen tap on that enable gives the transmit-bit enable.

Both outputs are single-cycle enable pulses in the system clock domain; no derived clock is ever created. A counter-clear input restarts all dividers from zero. Any change of the prescale or rate code also restarts them, so a new rate always begins with a clean, full first period. For example, prescale 13 with rate ratio 1 on a 2 MHz clock gives a sample rate near 153.6 kHz, which is about 9600 bit/s. A control byte of 0x30 selects this setting, with the prescale field in bits 5:4 and the rate field in bits 2:0.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescale code `pre_code` selects the first-stage ratio P: 2'b00 selects 1, 2'b01 selects 3, 2'b10 selects 4 and 2'b11 selects 13.
- R2: The rate code `sel_code` = n selects the second-stage ratio 2^n, from 1 for code 0 up to 128 for code 7.
- R3: With the codes held, and counting clock edges from the first edge that samples `cnt_clr` low after a restart, `rx_tick` is high after edges R, 2R, 3R and so on, where R = P·2^n. It is low after every other edge.
- R4: `tx_tick` is high after edge 16·R and then every 16·R edges. Each `tx_tick` coincides with every sixteenth `rx_tick`.
- R5: When R > 1, each `rx_tick` pulse lasts exactly one clock. `tx_tick` always lasts exactly one clock.
- R6: While `cnt_clr` is high, both outputs stay low and every divider counter is held at zero.
- R7: A clock edge that samples a prescale or rate code different from the one sampled on the edge before restarts all counters, in the same way as `cnt_clr`.
- R8: While `rst_n` is low, both outputs are low.
- R9: Prescale code 2'b11 with rate code 3'b000 gives an `rx_tick` every 13 clocks and a `tx_tick` every 208 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_code | input | 2 | Prescale ratio code |
| sel_code | input | 3 | Power-of-two rate code |
| cnt_clr | input | 1 | Synchronous counter clear |
| rx_tick | output | 1 | Receive-sample enable pulse |
| tx_tick | output | 1 | Transmit-bit enable pulse |

## Verification
The hardest condition to reach is the restart caused by a code change while a long period is partly counted. Only the edge that sees the new code may clear the counters. The stimulus runs the slowest setting for a while and then switches to a short ratio with no clear. It then checks that the first pulse lands exactly one new period after the switch edge. The full 16·R transmit period at the slowest setting (26624 clocks) is driven once directly. Random codes with shorter periods check the cascade alignment across the other ratios.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SEL_W  = 3,
  parameter int TX_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pre_code,
  input  logic [SEL_W-1:0] sel_code,
  input  logic             cnt_clr,
  output logic             rx_tick,
  output logic             tx_tick
);
  localparam int SCNT_W = (1 << SEL_W) - 1;
  localparam int TX_W   = $clog2(TX_DIV);

  logic [3:0]       pre_cnt, pre_last;
  logic [SCNT_W-1:0] sel_cnt, sel_mask;
  logic [SCNT_W:0]   sel_span;
  logic [TX_W-1:0]  tx_cnt;
  logic [1:0]       pre_q;
  logic [SEL_W-1:0] sel_q;
  logic             pre_hit, sel_hit, tx_hit, restart;

  always_comb begin
    case (pre_code)
      2'b00:   pre_last = 4'd0;
      2'b01:   pre_last = 4'd2;
      2'b10:   pre_last = 4'd3;
      default: pre_last = 4'd12;
    endcase
  end

  assign sel_span = (SCNT_W+1)'(1) << sel_code;
  assign sel_mask = SCNT_W'(sel_span - 1'b1);
  assign pre_hit  = (pre_cnt == pre_last);
  assign sel_hit  = (sel_cnt == sel_mask);
  assign tx_hit   = (tx_cnt == TX_W'(TX_DIV - 1));
  assign restart  = cnt_clr | (pre_code != pre_q) | (sel_code != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      sel_q   <= '0;
      pre_cnt <= '0;
      sel_cnt <= '0;
      tx_cnt  <= '0;
      rx_tick <= 1'b0;
      tx_tick <= 1'b0;
    end else begin
      pre_q <= pre_code;
      sel_q <= sel_code;
      if (restart) begin
        pre_cnt <= '0;
        sel_cnt <= '0;
        tx_cnt  <= '0;
        rx_tick <= 1'b0;
        tx_tick <= 1'b0;
      end else begin
        rx_tick <= pre_hit & sel_hit;
        tx_tick <= pre_hit & sel_hit & tx_hit;
        pre_cnt <= pre_hit ? '0 : pre_cnt + 4'd1;
        if (pre_hit)
          sel_cnt <= sel_hit ? '0 : sel_cnt + 1'b1;
        if (pre_hit && sel_hit)
          tx_cnt <= tx_hit ? '0 : tx_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pre_code,
  input logic [SEL_W-1:0] sel_code,
  input logic             cnt_clr,
  input logic             rx_tick,
  input logic             tx_tick
);
  assert_tx_with_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> rx_tick);

  assert_tx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick);

  assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && (pre_code != 2'b00 || sel_code != '0)) |=> !rx_tick);

  assert_clear_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (!rx_tick && !tx_tick));

  assert_code_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pre_code != $past(pre_code)) || (sel_code != $past(sel_code))) |-> ##1 (!rx_tick && !tx_tick));

  always_comb begin
    if (!rst_n) begin
      assert_reset_low_R8: assert (!rx_tick && !tx_tick);
    end
  end
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.SEL_W(SEL_W)) chk (
  .clk(clk), .rst_n(rst_n), .pre_code(pre_code), .sel_code(sel_code),
  .cnt_clr(cnt_clr), .rx_tick(rx_tick), .tx_tick(tx_tick)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pre_code = 2'b00;
  logic [2:0] sel_code = 3'b000;
  logic       cnt_clr = 1'b0;
  logic       rx_tick, tx_tick;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .pre_code(pre_code), .sel_code(sel_code),
    .cnt_clr(cnt_clr), .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  function automatic int pre_ratio(input logic [1:0] p);
    case (p)
      2'b00: return 1;
      2'b01: return 3;
      2'b10: return 4;
      default: return 13;
    endcase
  endfunction

  function automatic int full_ratio(input logic [1:0] p, input logic [2:0] s);
    return pre_ratio(p) * (1 << s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [1:0] p, input logic [2:0] s, input bit want_tx, input string req);
    int r = full_ratio(p, s);
    int lim = want_tx ? 16 * r + 1 : 2 * r + 1;
    int first_rx = -1, second_rx = -1, first_tx = -1, rxn = 0, rx_at_tx = -1;
    bit wide = 1'b0;
    @(negedge clk);
    pre_code = p; sel_code = s; cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    for (int e = 1; e <= lim; e++) begin
      @(posedge clk); #1;
      if (rx_tick) begin
        rxn++;
        if (first_rx < 0) first_rx = e;
        else if (second_rx < 0) second_rx = e;
      end
      if (tx_tick && first_tx < 0) begin first_tx = e; rx_at_tx = rxn; end
      if (r > 1 && e == r + 1 && rx_tick) wide = 1'b1;
    end
    check(first_rx == r, {req, " R3 first rx"}, first_rx, r);
    check(second_rx == 2 * r, {req, " R3 second rx"}, second_rx, 2 * r);
    if (r > 1) check(!wide, {req, " R5 rx width"}, int'(wide), 0);
    if (want_tx) begin
      check(first_tx == 16 * r, {req, " R4 first tx"}, first_tx, 16 * r);
      check(rx_at_tx == 16, {req, " R4 rx count at tx"}, rx_at_tx, 16);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      check(!rx_tick && !tx_tick, "R8 reset outputs", int'({rx_tick, tx_tick}), 0);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) run_case(2'(i), 3'd0, 1'b1, "R1 prescale");
    for (int i = 1; i < 8; i++) run_case(2'b00, 3'(i), i <= 4, "R2 select");
    run_case(2'b11, 3'd0, 1'b1, "R9 9600 setting");
    run_case(2'b11, 3'd7, 1'b1, "R3 slowest");

    for (int k = 0; k < 10; k++) begin
      logic [1:0] p = 2'($urandom_range(0, 3));
      logic [2:0] s = 3'($urandom_range(0, 7));
      run_case(p, s, full_ratio(p, s) <= 256, "R3 random");
    end

    begin
      int first_rx = -1;
      bit early = 1'b0;
      @(negedge clk);
      pre_code = 2'b11; sel_code = 3'd7; cnt_clr = 1'b1;
      @(negedge clk); cnt_clr = 1'b0;
      repeat (100) @(negedge clk);
      pre_code = 2'b01; sel_code = 3'd1;
      for (int e = 1; e <= 20; e++) begin
        @(posedge clk); #1;
        if (rx_tick && first_rx < 0) first_rx = e;
        if (e == 1 && (rx_tick || tx_tick)) early = 1'b1;
      end
      check(first_rx == 7, "R7 code change restart", first_rx, 7);
      check(!early, "R7 quiet on change edge", int'(early), 0);
    end

    begin
      int first_rx = -1;
      bit leak = 1'b0;
      @(negedge clk);
      pre_code = 2'b10; sel_code = 3'd2; cnt_clr = 1'b1;
      @(negedge clk); cnt_clr = 1'b0;
      repeat (10) @(negedge clk);
      cnt_clr = 1'b1;
      for (int e = 0; e < 40; e++) begin
        @(posedge clk); #1;
        if (rx_tick || tx_tick) leak = 1'b1;
      end
      check(!leak, "R6 outputs low during clear", int'(leak), 0);
      @(negedge clk); cnt_clr = 1'b0;
      for (int e = 1; e <= 20; e++) begin
        @(posedge clk); #1;
        if (rx_tick && first_rx < 0) first_rx = e;
      end
      check(first_rx == 16, "R6 restart after clear", first_rx, 16);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule